// File: doc/BRIEF.md
# Expansion Card CSR Responder

This block is the slave side of a plug-in I/O card on a simple processor local bus. The host presents a 20-bit offset together with a byte-region or word-region select and a read or write strobe, and the block answers with a ready pulse and, for reads, a 16-bit data word. The low part of the card's address window is a read-only identification region. It holds a fixed flag, its two's complement, revision bytes and a serial number. Above it sits a small control region that carries the card-type switch value and the interrupt exchange registers.

Interrupts run both ways without any vector cycle. The card side raises a request with an 8-bit cause code. The block latches that code where the host can read it and pulls the active-low host interrupt line down. The line stays down until the host writes the re-arm location. In the other direction, the host writes a cause code. This raises a card-side interrupt request that holds until the card logic acknowledges it. Every location the block does not implement reads as all ones. This covers the windows set aside for other on-card peripherals.

Top module: `xcard_csr_top`

## Requirements
- R1: A word read at offset 0x00000 returns the flag parameter (default 0xC35A), and a word read at offset 0x00002 returns its two's complement (default 0x3CA6).
- R2: A word read at 0x00004 returns {firmware revision, hardware revision} (defaults 0x34, 0x12), and a word read at 0x00006 returns the serial number (default 0xBEEF). A byte-region read returns the addressed byte in bits 7:0, with 0xFF in bits 15:8. An even offset selects the low byte of the halfword and an odd offset selects the high byte.
- R3: A read of any location that is not implemented returns 0xFFFF. This includes the rest of the identification region, the write-only offsets 0x40002 and 0x4000A, the unused control offsets, and every offset at or above 0x40010.
- R4: A word read at 0x40008 returns 0xFF in bits 15:8 and the current card-type switch input in bits 7:0.
- R5: An access is a cycle with a select and a strobe high. Ready goes high in the cycle after the access begins and lasts one cycle. The read data is valid while ready is high, and reads 0xFFFF whenever ready is low.
- R6: A cycle with cardIntReq high latches cardIntId and drives hostIntN low from the next cycle. The latched code reads at 0x40000 as {0xFF, code}. hostIntN stays low until the host writes 0x4000A.
- R7: A host write to 0x4000A releases hostIntN high on the next cycle. If cardIntReq is high in the same cycle as that write, the new request wins: hostIntN stays low and the new code is latched.
- R8: A host write to 0x40002 places data bits 7:0 on cardHostId and raises cardIrq on the next cycle. cardAck clears cardIrq. A write in the same cycle as cardAck wins, so cardIrq stays high.
- R9: Writes to read-only locations (0x00000, 0x40000, 0x40008) are ignored, and those locations read back unchanged afterwards.
- R10: After reset, hostIntN is high, cardIrq is low, cardHostId is 0x00, and offset 0x40000 reads 0xFF00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 20 | Offset within the card window |
| busWdata | input | 16 | Write data |
| selByte | input | 1 | Byte-region select |
| selWord | input | 1 | Word-region select |
| rdStb | input | 1 | Read strobe |
| wrStb | input | 1 | Write strobe |
| busReady | output | 1 | Access completion, one cycle |
| busRdata | output | 16 | Read data, all ones outside ready |
| cardTypeSw | input | 8 | Card-type switch setting |
| cardIntReq | input | 1 | Card-side interrupt request |
| cardIntId | input | 8 | Cause code for the card request |
| hostIntN | output | 1 | Active-low interrupt to host |
| cardIrq | output | 1 | Interrupt to card-side logic |
| cardHostId | output | 8 | Cause code posted by host |
| cardAck | input | 1 | Card-side acknowledge |

## Verification
Two conflicts can occur in the same cycle. A card-side request can land in the cycle the host's re-arm write commits, and a card acknowledge can land in the cycle a new host-to-card code is written. The bench provokes each one by raising cardIntReq or cardAck on the same falling edge that starts the write. The commit and the competing event therefore share the next rising edge. It then judges the outcome at the ports. hostIntN must stay low and 0x40000 must read the new code. cardIrq must stay high, and cardHostId must show the freshly written code.

// File: rtl/xcard_csr_pkg.sv
package xcard_csr_pkg;
  localparam int unsigned OFF_FLAG   = 'h00000;
  localparam int unsigned OFF_FLAGN  = 'h00002;
  localparam int unsigned OFF_REV    = 'h00004;
  localparam int unsigned OFF_SERIAL = 'h00006;
  localparam int unsigned OFF_C2H    = 'h40000;
  localparam int unsigned OFF_H2C    = 'h40002;
  localparam int unsigned OFF_TYPE   = 'h40008;
  localparam int unsigned OFF_REARM  = 'h4000A;

  typedef struct packed {
    logic capRead;
    logic wrHostId;
    logic wrRearm;
    logic byteMode;
  } csrStrobes_t;
endpackage

// File: rtl/xcard_csr_ctrl.sv
module xcard_csr_ctrl
  import xcard_csr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              selByte,
  input  logic              selWord,
  input  logic              rdStb,
  input  logic              wrStb,
  output logic              busReady,
  output csrStrobes_t       strb
);
  logic accNow;
  logic commit;
  logic readyQ;
  logic [ADDR_W-1:0] wordAddr;

  assign accNow   = (selByte | selWord) & (rdStb | wrStb);
  assign commit   = accNow & ~readyQ;
  assign wordAddr = {busAddr[ADDR_W-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= commit;
  end

  always_comb begin
    strb.capRead  = commit & rdStb;
    strb.wrHostId = commit & wrStb & (wordAddr == ADDR_W'(OFF_H2C));
    strb.wrRearm  = commit & wrStb & (wordAddr == ADDR_W'(OFF_REARM));
    strb.byteMode = selByte;
  end

  assign busReady = readyQ;
endmodule

// File: rtl/xcard_csr_dpath.sv
module xcard_csr_dpath
  import xcard_csr_pkg::*;
#(
  parameter int              ADDR_W = 20,
  parameter int              DATA_W = 16,
  parameter int              ID_W   = 8,
  parameter logic [15:0]     FLAG   = 16'hC35A,
  parameter logic [7:0]      HW_REV = 8'h12,
  parameter logic [7:0]      FW_REV = 8'h34,
  parameter logic [15:0]     SERIAL = 16'hBEEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  csrStrobes_t       strb,
  input  logic              busReady,
  output logic [DATA_W-1:0] busRdata,
  input  logic [ID_W-1:0]   cardTypeSw,
  input  logic              cardIntReq,
  input  logic [ID_W-1:0]   cardIntId,
  output logic              hostIntN,
  output logic              cardIrq,
  output logic [ID_W-1:0]   cardHostId,
  input  logic              cardAck
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [DATA_W-ID_W-1:0] PAD = '1;

  logic [ID_W-1:0]   c2hId;
  logic              hostIntQ;
  logic [ID_W-1:0]   h2cId;
  logic              cardIrqQ;
  logic [DATA_W-1:0] rdQ;
  logic [DATA_W-1:0] wordVal;
  logic [DATA_W-1:0] rdVal;
  logic [ADDR_W-1:0] wordAddr;

  assign wordAddr = {busAddr[ADDR_W-1:1], 1'b0};

  always_comb begin
    unique case (wordAddr)
      ADDR_W'(OFF_FLAG):   wordVal = DATA_W'(FLAG);
      ADDR_W'(OFF_FLAGN):  wordVal = DATA_W'(-FLAG);
      ADDR_W'(OFF_REV):    wordVal = DATA_W'({FW_REV, HW_REV});
      ADDR_W'(OFF_SERIAL): wordVal = DATA_W'(SERIAL);
      ADDR_W'(OFF_C2H):    wordVal = {PAD, c2hId};
      ADDR_W'(OFF_TYPE):   wordVal = {PAD, cardTypeSw};
      default:             wordVal = ONES;
    endcase
  end

  always_comb begin
    if (strb.byteMode)
      rdVal = {{(DATA_W-HALF_W){1'b1}},
               busAddr[0] ? wordVal[DATA_W-1:HALF_W] : wordVal[HALF_W-1:0]};
    else
      rdVal = wordVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      c2hId    <= '0;
      hostIntQ <= 1'b0;
      h2cId    <= '0;
      cardIrqQ <= 1'b0;
      rdQ      <= ONES;
    end else begin
      if (cardIntReq) begin
        c2hId    <= cardIntId;
        hostIntQ <= 1'b1;
      end else if (strb.wrRearm) begin
        hostIntQ <= 1'b0;
      end
      if (strb.wrHostId) begin
        h2cId    <= busWdata[ID_W-1:0];
        cardIrqQ <= 1'b1;
      end else if (cardAck) begin
        cardIrqQ <= 1'b0;
      end
      if (strb.capRead) rdQ <= rdVal;
    end
  end

  assign busRdata   = busReady ? rdQ : ONES;
  assign hostIntN   = ~hostIntQ;
  assign cardIrq    = cardIrqQ;
  assign cardHostId = h2cId;
endmodule

// File: rtl/xcard_csr_top.sv
module xcard_csr_top
  import xcard_csr_pkg::*;
#(
  parameter int          ADDR_W = 20,
  parameter int          DATA_W = 16,
  parameter int          ID_W   = 8,
  parameter logic [15:0] FLAG   = 16'hC35A,
  parameter logic [7:0]  HW_REV = 8'h12,
  parameter logic [7:0]  FW_REV = 8'h34,
  parameter logic [15:0] SERIAL = 16'hBEEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              selByte,
  input  logic              selWord,
  input  logic              rdStb,
  input  logic              wrStb,
  output logic              busReady,
  output logic [DATA_W-1:0] busRdata,
  input  logic [ID_W-1:0]   cardTypeSw,
  input  logic              cardIntReq,
  input  logic [ID_W-1:0]   cardIntId,
  output logic              hostIntN,
  output logic              cardIrq,
  output logic [ID_W-1:0]   cardHostId,
  input  logic              cardAck
);
  csrStrobes_t strb;

  xcard_csr_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .selByte(selByte), .selWord(selWord), .rdStb(rdStb), .wrStb(wrStb),
    .busReady(busReady), .strb(strb)
  );

  xcard_csr_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .FLAG(FLAG),
    .HW_REV(HW_REV), .FW_REV(FW_REV), .SERIAL(SERIAL)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .strb(strb), .busReady(busReady), .busRdata(busRdata),
    .cardTypeSw(cardTypeSw), .cardIntReq(cardIntReq), .cardIntId(cardIntId),
    .hostIntN(hostIntN), .cardIrq(cardIrq), .cardHostId(cardHostId),
    .cardAck(cardAck)
  );
endmodule

// File: rtl/xcard_csr_chk.sv
module xcard_csr_chk
  import xcard_csr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int ID_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              selByte,
  input logic              selWord,
  input logic              rdStb,
  input logic              wrStb,
  input logic              busReady,
  input logic [DATA_W-1:0] busRdata,
  input logic              cardIntReq,
  input logic              hostIntN,
  input logic              cardIrq,
  input logic              cardAck
);
  logic accIn;
  logic wordIsRearm;
  logic wordIsH2c;
  assign accIn       = (selByte | selWord) & (rdStb | wrStb);
  assign wordIsRearm = ({busAddr[ADDR_W-1:1], 1'b0} == ADDR_W'(OFF_REARM));
  assign wordIsH2c   = ({busAddr[ADDR_W-1:1], 1'b0} == ADDR_W'(OFF_H2C));

  // R5: ready follows a fresh access by one cycle
  a_r5_ready_after_access: assert property (@(posedge clk) disable iff (!rstN)
    (accIn && !busReady) |=> busReady);

  // R5: no valid data outside ready
  a_r5_idle_ones: assert property (@(posedge clk) disable iff (!rstN)
    !busReady |-> (busRdata == '1));

  // R6: host line only drops after a card request
  a_r6_fall_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostIntN) |-> $past(cardIntReq));

  // R7: re-arm write with no competing request releases the line
  a_r7_rearm_release: assert property (@(posedge clk) disable iff (!rstN)
    (accIn && !busReady && wrStb && wordIsRearm && !cardIntReq) |=> hostIntN);

  // R7: a same-cycle request keeps the line low
  a_r7_req_wins: assert property (@(posedge clk) disable iff (!rstN)
    cardIntReq |=> !hostIntN);

  // R8: host-to-card write raises the card interrupt, even against an ack
  a_r8_post_raises: assert property (@(posedge clk) disable iff (!rstN)
    (accIn && !busReady && wrStb && wordIsH2c) |=> cardIrq);

  // R8: card interrupt falls only on acknowledge
  a_r8_fall_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cardIrq) |-> $past(cardAck));
endmodule

bind xcard_csr_top xcard_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .selByte(selByte), .selWord(selWord),
  .rdStb(rdStb), .wrStb(wrStb), .busReady(busReady), .busRdata(busRdata),
  .cardIntReq(cardIntReq), .hostIntN(hostIntN), .cardIrq(cardIrq), .cardAck(cardAck)
);

// File: tb/xcard_csr_top_tb_top.sv
module xcard_csr_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] busAddr = '0;
  logic [15:0] busWdata = '0;
  logic        selByte = 1'b0, selWord = 1'b0, rdStb = 1'b0, wrStb = 1'b0;
  logic        busReady;
  logic [15:0] busRdata;
  logic [7:0]  cardTypeSw = 8'h5C;
  logic        cardIntReq = 1'b0;
  logic [7:0]  cardIntId = '0;
  logic        hostIntN, cardIrq;
  logic [7:0]  cardHostId;
  logic        cardAck = 1'b0;

  int vecCount = 0;
  int failCount = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcard_csr_top dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .selByte(selByte), .selWord(selWord), .rdStb(rdStb), .wrStb(wrStb),
    .busReady(busReady), .busRdata(busRdata), .cardTypeSw(cardTypeSw),
    .cardIntReq(cardIntReq), .cardIntId(cardIntId), .hostIntN(hostIntN),
    .cardIrq(cardIrq), .cardHostId(cardHostId), .cardAck(cardAck)
  );

  // {addr, byte select, expected read data}
  typedef struct packed { logic [19:0] addr; logic isByte; logic [15:0] exp; } vec_t;
  localparam vec_t VECS [NVEC] = '{
    '{20'h00000, 1'b0, 16'hC35A},  // R1
    '{20'h00002, 1'b0, 16'h3CA6},  // R1
    '{20'h00004, 1'b0, 16'h3412},  // R2
    '{20'h00004, 1'b1, 16'hFF12},  // R2
    '{20'h00005, 1'b1, 16'hFF34},  // R2
    '{20'h00006, 1'b0, 16'hBEEF},  // R2
    '{20'h00001, 1'b1, 16'hFFC3},  // R2
    '{20'h00010, 1'b0, 16'hFFFF},  // R3
    '{20'h3FFFE, 1'b0, 16'hFFFF},  // R3
    '{20'h40002, 1'b0, 16'hFFFF},  // R3
    '{20'h40004, 1'b0, 16'hFFFF},  // R3
    '{20'h4000A, 1'b0, 16'hFFFF},  // R3
    '{20'h40100, 1'b0, 16'hFFFF},  // R3
    '{20'h80000, 1'b0, 16'hFFFF},  // R3
    '{20'h40008, 1'b0, 16'hFF5C},  // R4
    '{20'h40000, 1'b0, 16'hFF00}   // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drives at a falling edge; the access commits at the next rising edge.
  task automatic busRead(input logic [19:0] a, input logic isByte, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; selByte = isByte; selWord = ~isByte; rdStb = 1'b1;
    #1;
    check("R5 ready low at start", {31'd0, busReady}, 32'd0);
    check("R5 data ones at start", {16'd0, busRdata}, 32'h0000FFFF);
    @(negedge clk);
    check("R5 ready one cycle on", {31'd0, busReady}, 32'd1);
    d = busRdata;
    selByte = 1'b0; selWord = 1'b0; rdStb = 1'b0;
  endtask

  task automatic startWrite(input logic [19:0] a, input logic [15:0] w);
    @(negedge clk);
    busAddr = a; busWdata = w; selWord = 1'b1; wrStb = 1'b1;
  endtask

  task automatic endWrite();
    @(negedge clk);
    selWord = 1'b0; wrStb = 1'b0;
    cardIntReq = 1'b0; cardAck = 1'b0;
  endtask

  task automatic busWrite(input logic [19:0] a, input logic [15:0] w);
    startWrite(a, w);
    endWrite();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 hostIntN after reset", {31'd0, hostIntN}, 32'd1);
    check("R10 cardIrq after reset", {31'd0, cardIrq}, 32'd0);
    check("R10 cardHostId after reset", {24'd0, cardHostId}, 32'd0);
    check("R5 ready idle", {31'd0, busReady}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      busRead(VECS[i].addr, VECS[i].isByte, d);
      check($sformatf("R1-4 vector %0d", i), {16'd0, d}, {16'd0, VECS[i].exp});
    end

    // R4: switch value followed live
    cardTypeSw = 8'h81;
    busRead(20'h40008, 1'b0, d);
    check("R4 switch change", {16'd0, d}, 32'h0000FF81);

    // R9: writes to read-only locations are ignored
    busWrite(20'h00000, 16'h1234);
    busRead(20'h00000, 1'b0, d);
    check("R9 flag unchanged", {16'd0, d}, 32'h0000C35A);
    busWrite(20'h40008, 16'h0000);
    busRead(20'h40008, 1'b0, d);
    check("R9 type unchanged", {16'd0, d}, 32'h0000FF81);
    busWrite(20'h40000, 16'h0055);
    busRead(20'h40000, 1'b0, d);
    check("R9 c2h id unchanged", {16'd0, d}, 32'h0000FF00);
    check("R9 no interrupt from write", {31'd0, hostIntN}, 32'd1);

    // R6: card raises an interrupt
    @(negedge clk);
    cardIntReq = 1'b1; cardIntId = 8'hA7;
    @(negedge clk);
    cardIntReq = 1'b0; cardIntId = 8'h00;
    check("R6 hostIntN low", {31'd0, hostIntN}, 32'd0);
    repeat (4) @(negedge clk);
    check("R6 hostIntN held", {31'd0, hostIntN}, 32'd0);
    busRead(20'h40000, 1'b0, d);
    check("R6 c2h id", {16'd0, d}, 32'h0000FFA7);

    // R7: re-arm releases
    busWrite(20'h4000A, 16'h0000);
    check("R7 hostIntN released", {31'd0, hostIntN}, 32'd1);

    // R7: same-cycle request beats re-arm
    busWrite(20'h4000A, 16'h0000);
    startWrite(20'h4000A, 16'h0000);
    cardIntReq = 1'b1; cardIntId = 8'h3C;
    endWrite();
    check("R7 request wins", {31'd0, hostIntN}, 32'd0);
    busRead(20'h40000, 1'b0, d);
    check("R7 new code latched", {16'd0, d}, 32'h0000FF3C);
    busWrite(20'h4000A, 16'h0000);
    check("R7 released after", {31'd0, hostIntN}, 32'd1);

    // R8: host posts a code
    busWrite(20'h40002, 16'h5A69);
    check("R8 cardIrq set", {31'd0, cardIrq}, 32'd1);
    check("R8 code", {24'd0, cardHostId}, 32'h69);
    @(negedge clk); cardAck = 1'b1;
    @(negedge clk); cardAck = 1'b0;
    check("R8 ack clears", {31'd0, cardIrq}, 32'd0);

    // R8: same-cycle ack loses to new write
    startWrite(20'h40002, 16'h0011);
    cardAck = 1'b1;
    endWrite();
    check("R8 write wins", {31'd0, cardIrq}, 32'd1);
    check("R8 new code", {24'd0, cardHostId}, 32'h11);
    @(negedge clk); cardAck = 1'b1;
    @(negedge clk); cardAck = 1'b0;
    check("R8 cleared after", {31'd0, cardIrq}, 32'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule